// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit virtual address into a 40-bit physical address by reading one table entry from memory at each of four levels. A requester hands over the virtual address with its access attributes (write, user mode, instruction fetch). The walk starts from a root-table frame number and follows the frame number in each fetched entry down to the last level. That last entry supplies the 4 KB page frame, and the page offset is appended to it.

The walker first checks that the address is canonical. At every level it then checks the entry for the present flag, for reserved bits and for permission bits. It holds at most one memory read outstanding and waits for the response for as long as it takes. Each request ends with a one-cycle completion pulse. The pulse carries either the physical address or a fault code, together with the level at which the walk stopped.

Top module: `page_walker`

## Requirements
- R1: A request whose address bits 63:48 do not all equal bit 47 completes with fault code 1 and level 0, and no memory read is issued for it. Canonical addresses with bit 47 set are walked normally.
- R2: The level-4 entry is read at byte address {root frame, va[47:39], 3'b000}. The level-3, level-2 and level-1 entries are read at {frame of the entry above, index, 3'b000}, where the index is va[38:30], va[29:21] and va[20:12] respectively. A walk that succeeds makes exactly four reads, and a walk that faults at level L makes 5-L reads.
- R3: An entry whose bit 0 (present) is clear ends the walk with fault code 2 at that entry's level.
- R4: A present entry with any of bits 51:40 set ends the walk with fault code 3 at that level. A clear present flag takes precedence over reserved bits.
- R5: A write request faults with code 4 at the first level whose entry has bit 1 (writable) clear.
- R6: A user-mode request faults with code 5 at the first level whose entry has bit 2 (user) clear. If one entry fails both the write check and the user check, code 4 is reported.
- R7: An instruction fetch faults with code 6 at the first level whose entry has bit 63 set, but only while the execute-disable enable input is high. While that input is low, bit 63 has no effect on the result.
- R8: A walk that succeeds reports fault flag 0, code 0, level 1 and physical address {level-1 frame (entry bits 39:12), va[11:0]}. Entry bits 62:52 and 11:3 do not affect the result. The fault flag is 1 exactly when the code is nonzero.
- R9: req_ready_o is high only while the walker is idle and drops in the cycle after a request is accepted. The walker never has more than one memory read outstanding, and it accepts a response after any number of wait cycles.
- R10: done_o is a single-cycle pulse, one per accepted request. After reset the walker is idle: ready is high, and done and the read strobe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle and able to accept a request |
| req_vaddr_i | input | 64 | Virtual address to translate |
| req_write_i | input | 1 | Request is a write |
| req_user_i | input | 1 | Request comes from user mode |
| req_fetch_i | input | 1 | Request is an instruction fetch |
| root_frame_i | input | 28 | Frame number of the level-4 table |
| xd_en_i | input | 1 | Enables execute-disable checking |
| mem_rd_valid_o | output | 1 | One-cycle read request strobe |
| mem_rd_addr_o | output | 40 | Byte address of the entry being read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Table entry returned by memory |
| done_o | output | 1 | Completion pulse |
| done_paddr_o | output | 40 | Physical address (valid when no fault) |
| done_fault_o | output | 1 | Walk ended in a fault |
| done_code_o | output | 3 | Fault code (0 none, 1 non-canonical, 2 not present, 3 reserved, 4 write, 5 user, 6 execute) |
| done_level_o | output | 3 | Level where the walk stopped (0 for a non-canonical address) |

## Verification
The checker watches the handshake and the memory port on every cycle. It checks that no read is issued while another is still outstanding, that ready drops after a request is accepted, that done lasts one cycle, and that a non-canonical request completes on the next cycle without a read. It also checks that the first read lands at the root-table slot chosen by va[47:39], and that fault flag, code and level agree with one another. The bench scenarios are needed for everything else: which fault wins on a given entry, the level at which each permission failure is caught, how the enable input gates execute-disable, that the available bits are ignored, the assembled physical address, and the number of reads per walk under memory latencies from zero to five cycles.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int VA_W    = 64;
  localparam int PA_W    = 40;
  localparam int OFF_W   = 12;
  localparam int IDX_W   = 9;
  localparam int LEVELS  = 4;
  localparam int PTE_W   = 64;
  localparam int FRAME_W = PA_W - OFF_W;
  localparam int SIGN_B  = OFF_W + LEVELS * IDX_W - 1;
  localparam int ENT_SH  = $clog2(PTE_W / 8);
  localparam int RSV_HI  = 51;
  localparam int RSV_LO  = PA_W;
  localparam int XD_B    = 63;
  localparam int LVL_W   = $clog2(LEVELS + 1);

  typedef enum logic [2:0] {
    F_NONE     = 3'd0,
    F_NONCANON = 3'd1,
    F_ABSENT   = 3'd2,
    F_RSVD     = 3'd3,
    F_WRITE    = 3'd4,
    F_USER     = 3'd5,
    F_EXEC     = 3'd6
  } fault_e;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_FIN} state_e;
endpackage

// File: rtl/pw_va_split.sv
module pw_va_split
  import pw_pkg::*;
(
  input  logic [VA_W-1:0]  va_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             canon_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [OFF_W-1:0] off_o
);
  logic [IDX_W-1:0] idx_tab [LEVELS];

  // idx_tab[0] is the level-1 index
  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx_tab[g] = va_i[OFF_W + g*IDX_W +: IDX_W];
  end

  always_comb begin
    idx_o = '0;
    for (int l = 0; l < LEVELS; l++)
      if (level_i == LVL_W'(l + 1)) idx_o = idx_tab[l];
  end

  assign canon_o = (&va_i[VA_W-1:SIGN_B]) | ~(|va_i[VA_W-1:SIGN_B]);
  assign off_o   = va_i[OFF_W-1:0];
endmodule

// File: rtl/pw_pte_eval.sv
module pw_pte_eval
  import pw_pkg::*;
(
  input  logic [PTE_W-1:0]   pte_i,
  input  logic               wr_i,
  input  logic               us_i,
  input  logic               fx_i,
  input  logic               xd_en_i,
  output fault_e             code_o,
  output logic [FRAME_W-1:0] frame_o
);
  logic unused_bits;
  assign unused_bits = ^{pte_i[XD_B-1:RSV_HI+1], pte_i[OFF_W-1:3]};

  // priority: present, reserved, write, user, execute
  always_comb begin
    code_o = F_NONE;
    if (!pte_i[0])                          code_o = F_ABSENT;
    else if (|pte_i[RSV_HI:RSV_LO])         code_o = F_RSVD;
    else if (wr_i && !pte_i[1])             code_o = F_WRITE;
    else if (us_i && !pte_i[2])             code_o = F_USER;
    else if (fx_i && xd_en_i && pte_i[XD_B]) code_o = F_EXEC;
  end

  assign frame_o = pte_i[PA_W-1:OFF_W];
endmodule

// File: rtl/page_walker.sv
module page_walker
  import pw_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [VA_W-1:0]    req_vaddr_i,
  input  logic               req_write_i,
  input  logic               req_user_i,
  input  logic               req_fetch_i,
  input  logic [FRAME_W-1:0] root_frame_i,
  input  logic               xd_en_i,
  output logic               mem_rd_valid_o,
  output logic [PA_W-1:0]    mem_rd_addr_o,
  input  logic               mem_rsp_valid_i,
  input  logic [PTE_W-1:0]   mem_rsp_data_i,
  output logic               done_o,
  output logic [PA_W-1:0]    done_paddr_o,
  output logic               done_fault_o,
  output logic [2:0]         done_code_o,
  output logic [LVL_W-1:0]   done_level_o
);
  state_e             state_q;
  logic [VA_W-1:0]    va_q;
  logic               wr_q, us_q, fx_q, xd_q;
  logic [LVL_W-1:0]   lvl_q;
  logic [FRAME_W-1:0] base_q;
  fault_e             code_q;
  logic [LVL_W-1:0]   res_lvl_q;
  logic [PA_W-1:0]    paddr_q;

  logic [VA_W-1:0]    va_sel;
  logic               canon;
  logic [IDX_W-1:0]   idx;
  logic [OFF_W-1:0]   off;
  fault_e             pte_code;
  logic [FRAME_W-1:0] pte_frame;

  // idle: inspect the incoming address; otherwise the latched one
  assign va_sel = (state_q == S_IDLE) ? req_vaddr_i : va_q;

  pw_va_split u_split (
    .va_i    (va_sel),
    .level_i (lvl_q),
    .canon_o (canon),
    .idx_o   (idx),
    .off_o   (off)
  );

  pw_pte_eval u_eval (
    .pte_i   (mem_rsp_data_i),
    .wr_i    (wr_q),
    .us_i    (us_q),
    .fx_i    (fx_q),
    .xd_en_i (xd_q),
    .code_o  (pte_code),
    .frame_o (pte_frame)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      va_q      <= '0;
      wr_q      <= 1'b0;
      us_q      <= 1'b0;
      fx_q      <= 1'b0;
      xd_q      <= 1'b0;
      lvl_q     <= '0;
      base_q    <= '0;
      code_q    <= F_NONE;
      res_lvl_q <= '0;
      paddr_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          va_q   <= req_vaddr_i;
          wr_q   <= req_write_i;
          us_q   <= req_user_i;
          fx_q   <= req_fetch_i;
          xd_q   <= xd_en_i;
          base_q <= root_frame_i;
          lvl_q  <= LVL_W'(LEVELS);
          if (!canon) begin
            code_q    <= F_NONCANON;
            res_lvl_q <= '0;
            paddr_q   <= '0;
            state_q   <= S_FIN;
          end else begin
            state_q <= S_ISSUE;
          end
        end
        S_ISSUE: state_q <= S_WAIT;
        S_WAIT: if (mem_rsp_valid_i) begin
          if (pte_code != F_NONE) begin
            code_q    <= pte_code;
            res_lvl_q <= lvl_q;
            paddr_q   <= '0;
            state_q   <= S_FIN;
          end else if (lvl_q == LVL_W'(1)) begin
            code_q    <= F_NONE;
            res_lvl_q <= lvl_q;
            paddr_q   <= {pte_frame, off};
            state_q   <= S_FIN;
          end else begin
            lvl_q   <= lvl_q - LVL_W'(1);
            base_q  <= pte_frame;
            state_q <= S_ISSUE;
          end
        end
        S_FIN: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o    = (state_q == S_IDLE);
  assign mem_rd_valid_o = (state_q == S_ISSUE);
  assign mem_rd_addr_o  = {base_q, idx, ENT_SH'(0)};
  assign done_o         = (state_q == S_FIN);
  assign done_paddr_o   = paddr_q;
  assign done_fault_o   = (code_q != F_NONE);
  assign done_code_o    = code_q;
  assign done_level_o   = res_lvl_q;
endmodule

// File: rtl/pw_checker.sv
module pw_checker
  import pw_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic [VA_W-1:0]    req_vaddr_i,
  input logic               req_write_i,
  input logic               req_user_i,
  input logic               req_fetch_i,
  input logic [FRAME_W-1:0] root_frame_i,
  input logic               xd_en_i,
  input logic               mem_rd_valid_o,
  input logic [PA_W-1:0]    mem_rd_addr_o,
  input logic               mem_rsp_valid_i,
  input logic [PTE_W-1:0]   mem_rsp_data_i,
  input logic               done_o,
  input logic [PA_W-1:0]    done_paddr_o,
  input logic               done_fault_o,
  input logic [2:0]         done_code_o,
  input logic [LVL_W-1:0]   done_level_o
);
  logic accept, in_noncanon, outstanding, first_pend;
  logic [PA_W-1:0] first_addr;

  assign accept      = req_valid_i && req_ready_o;
  assign in_noncanon = !((&req_vaddr_i[VA_W-1:SIGN_B]) || !(|req_vaddr_i[VA_W-1:SIGN_B]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      outstanding <= 1'b0;
      first_pend  <= 1'b0;
      first_addr  <= '0;
    end else begin
      if (mem_rd_valid_o) outstanding <= 1'b1;
      else if (mem_rsp_valid_i) outstanding <= 1'b0;
      if (accept && !in_noncanon) begin
        first_pend <= 1'b1;
        first_addr <= {root_frame_i, req_vaddr_i[SIGN_B -: IDX_W], ENT_SH'(0)};
      end else if (mem_rd_valid_o) begin
        first_pend <= 1'b0;
      end
    end
  end

  a_r9_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_valid_o |-> !outstanding);
  a_r9_ready_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !req_ready_o);
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r1_noncanon_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && in_noncanon) |=> (done_o && done_code_o == 3'd1 && !mem_rd_valid_o));
  a_r1_noncanon_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && done_code_o == 3'd1) |-> done_level_o == '0);
  a_r2_first_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_valid_o && first_pend) |-> mem_rd_addr_o == first_addr);
  a_r8_fault_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (done_fault_o == (done_code_o != 3'd0)));
  a_r8_ok_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !done_fault_o) |-> done_level_o == LVL_W'(1));
endmodule

bind page_walker pw_checker u_chk (.*);

// File: tb/page_walker_bench.sv
module page_walker_bench;
  localparam int CLK_PERIOD = 10;

  localparam logic [63:0] A_OK = 64'h7;
  localparam logic [63:0] XD   = 64'h8000_0000_0000_0000;
  localparam logic [63:0] RSV  = 64'h0000_2000_0000_0000;
  localparam logic [63:0] AVL  = 64'h7FF0_0000_0000_0E00;
  localparam logic [27:0] ROOT = 28'h1;

  typedef struct packed {
    logic [11:0] off;
    logic [63:0] a4, a3, a2, a1;
    logic wr, us, fx, xd;
    logic [2:0] code;
    logic [2:0] lvl;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{12'h123, A_OK, A_OK, A_OK, A_OK,          1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd1},
    '{12'hABC, A_OK, A_OK, A_OK, A_OK,          1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 3'd1},
    '{12'h001, A_OK, A_OK, 64'h5, A_OK,         1'b1, 1'b0, 1'b0, 1'b0, 3'd4, 3'd2},
    '{12'h002, A_OK, 64'h3, A_OK, A_OK,         1'b0, 1'b1, 1'b0, 1'b0, 3'd5, 3'd3},
    '{12'hFFF, A_OK, A_OK, A_OK, A_OK,          1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 3'd1},
    '{12'h010, A_OK, A_OK, A_OK, A_OK | XD,     1'b0, 1'b0, 1'b1, 1'b1, 3'd6, 3'd1},
    '{12'h020, A_OK, A_OK, A_OK, A_OK | XD,     1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 3'd1},
    '{12'h030, 64'h6, A_OK, A_OK, A_OK,         1'b0, 1'b0, 1'b0, 1'b0, 3'd2, 3'd4},
    '{12'h040, A_OK, A_OK, A_OK, A_OK | RSV,    1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 3'd1},
    '{12'h050, A_OK, A_OK, 64'h6 | RSV, A_OK,   1'b0, 1'b0, 1'b0, 1'b0, 3'd2, 3'd2},
    '{12'h060, A_OK, 64'h5, A_OK, A_OK,         1'b1, 1'b1, 1'b0, 1'b0, 3'd4, 3'd3},
    '{12'h070, A_OK | AVL, A_OK, A_OK, A_OK,    1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0, req_fetch = 1'b0, xd_en = 1'b0;
  logic [63:0] req_vaddr = '0;
  logic mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic req_ready, mem_rd_valid, done, done_fault;
  logic [39:0] mem_rd_addr, done_paddr;
  logic [2:0] done_code, done_level;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_walker u_page_walker (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
    .req_write_i(req_write), .req_user_i(req_user), .req_fetch_i(req_fetch),
    .root_frame_i(ROOT), .xd_en_i(xd_en),
    .mem_rd_valid_o(mem_rd_valid), .mem_rd_addr_o(mem_rd_addr),
    .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_data_i(mem_rsp_data),
    .done_o(done), .done_paddr_o(done_paddr), .done_fault_o(done_fault),
    .done_code_o(done_code), .done_level_o(done_level)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  logic [63:0] mem [logic [39:0]];
  int mem_lat = 0, reads = 0;
  logic [27:0] next_frame = 28'h100;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model: one response per read, mem_lat idle cycles first
  initial begin
    bit pend = 1'b0;
    int cnt = 0;
    logic [39:0] a = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem.exists(a) ? mem[a] : 64'h0;
          pend = 1'b0;
        end else cnt--;
      end
      if (mem_rd_valid) begin
        pend = 1'b1; a = mem_rd_addr; cnt = mem_lat; reads++;
      end
    end
  end

  function automatic logic [63:0] ent(input logic [27:0] fr, input logic [63:0] attr);
    return attr | {24'h0, fr, 12'h0};
  endfunction

  task automatic build(input logic [63:0] va, input logic [63:0] a4, a3, a2, a1,
                       input logic [27:0] fin);
    logic [27:0] f3, f2, f1;
    f3 = next_frame; f2 = next_frame + 1; f1 = next_frame + 2;
    next_frame += 3;
    mem[{ROOT, va[47:39], 3'b000}] = ent(f3, a4);
    mem[{f3,   va[38:30], 3'b000}] = ent(f2, a3);
    mem[{f2,   va[29:21], 3'b000}] = ent(f1, a2);
    mem[{f1,   va[20:12], 3'b000}] = ent(fin, a1);
  endtask

  task automatic walk(input logic [63:0] va, input logic wr, us, fx, xe,
                      output logic [2:0] code, output logic [2:0] lvl,
                      output logic [39:0] pa, output logic flt, output int nrd);
    int n = 0;
    @(negedge clk);
    reads = 0;
    req_vaddr = va; req_write = wr; req_user = us; req_fetch = fx; xd_en = xe;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R9", "ready low after accept", 64'(req_ready), 64'h0);
    while (!done && n < 200) begin @(negedge clk); n++; end
    chk(done == 1'b1, "R10", "done seen", 64'(done), 64'h1);
    code = done_code; lvl = done_level; pa = done_paddr; flt = done_fault; nrd = reads;
    @(negedge clk);
    chk(done == 1'b0, "R10", "done single cycle", 64'(done), 64'h0);
    chk(req_ready == 1'b1, "R9", "ready back after done", 64'(req_ready), 64'h1);
  endtask

  function automatic string tag(input logic [2:0] c);
    case (c)
      3'd1: return "R1";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [2:0] c, l;
    logic [39:0] pa;
    logic f;
    int nr;
    logic [63:0] va;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(req_ready == 1'b1, "R10", "reset ready", 64'(req_ready), 64'h1);
    chk(done == 1'b0, "R10", "reset done", 64'(done), 64'h0);
    chk(mem_rd_valid == 1'b0, "R10", "reset read strobe", 64'(mem_rd_valid), 64'h0);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      logic [39:0] exp_pa;
      int exp_rd;
      va = {16'h0, 9'(i + 1), 9'(i + 3), 9'(i + 5), 9'(i + 7), v.off};
      build(va, v.a4, v.a3, v.a2, v.a1, 28'h80000 + 28'(i));
      mem_lat = i % 4;
      walk(va, v.wr, v.us, v.fx, v.xd, c, l, pa, f, nr);
      chk(c == v.code, tag(v.code), $sformatf("vec %0d code", i), 64'(c), 64'(v.code));
      chk(l == v.lvl, tag(v.code), $sformatf("vec %0d level", i), 64'(l), 64'(v.lvl));
      chk(f == (v.code != 0), "R8", $sformatf("vec %0d fault flag", i), 64'(f), 64'(v.code != 0));
      exp_rd = (v.code == 0) ? 4 : 5 - int'(v.lvl);
      chk(nr == exp_rd, "R2", $sformatf("vec %0d reads", i), 64'(nr), 64'(exp_rd));
      if (v.code == 0) begin
        exp_pa = {28'h80000 + 28'(i), v.off};
        chk(pa == exp_pa, "R8", $sformatf("vec %0d paddr", i), 64'(pa), 64'(exp_pa));
      end
    end

    // R1 non-canonical: upper bits set with bit 47 clear, and the reverse
    walk(64'h0001_0000_0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, c, l, pa, f, nr);
    chk(c == 3'd1, "R1", "noncanon code", 64'(c), 64'h1);
    chk(l == 3'd0, "R1", "noncanon level", 64'(l), 64'h0);
    chk(nr == 0, "R1", "noncanon reads", 64'(nr), 64'h0);
    walk(64'h7FFF_8000_0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, c, l, pa, f, nr);
    chk(c == 3'd1 && f, "R1", "noncanon high code", 64'(c), 64'h1);
    chk(nr == 0, "R1", "noncanon high reads", 64'(nr), 64'h0);

    // R1 canonical negative address, long memory latency (R9)
    va = 64'hFFFF_8000_0040_2123;
    build(va, A_OK, A_OK, A_OK, A_OK, 28'hABCDE);
    mem_lat = 5;
    walk(va, 1'b1, 1'b1, 1'b1, 1'b1, c, l, pa, f, nr);
    chk(c == 3'd0, "R1", "canonical high code", 64'(c), 64'h0);
    chk(pa == {28'hABCDE, 12'h123}, "R8", "canonical high paddr", 64'(pa), 64'({28'hABCDE, 12'h123}));
    chk(nr == 4, "R9", "slow memory reads", 64'(nr), 64'h4);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule